// File: doc/BRIEF.md
# Daisy-Chainable Serial Diagnosis Port

This block is the serial slave front end of a control and diagnosis register interface. A host selects it with an active-low select line, clocks data with a serial clock and exchanges one 16-bit word in each direction per access. When the access opens, the block loads the diagnosis word into its shift register. It shifts that word out MSB first while it shifts the command word in. When the access closes, it hands the received word to the command decoder with a one-cycle strobe.

The block accepts an access only if the number of clocked bits is a multiple of 8 and is at least 16. Several of these blocks, or a mix with 8-bit devices, can therefore share one select line in a daisy chain. The last 16 bits shifted in are kept. Earlier bits leave on the serial output toward the next device. A sticky transmission error flag is set by reset and by every rejected access, and cleared by every accepted one. The flag is visible to the host on the serial output at the start of the next access.

All serial inputs are synchronized to a faster system clock, and their edges are detected in that domain.

Top module: `spi_diag_slave`

## Requirements
- R1: While the synchronized select is high, activity on the serial clock and data inputs changes no state: no bit is counted, no bit is shifted and no strobe is produced.
- R2: Inside an access, serial data is sampled on the falling serial clock edge and the serial output changes on the rising edge. Both directions are MSB first.
- R3: The output enable `so_oe_o` is low while select is high and high while select is low.
- R4: On the select falling edge, `diag_i` is copied into the shift register. The first 16 bits on the serial output after the first rising clock edge are `diag_i`, MSB first.
- R5: From the select falling edge until the first rising serial clock edge, the serial output equals the error flag ORed with the current serial data input level.
- R6: On the select rising edge, the access is accepted only if the bit count is a multiple of 8 and at least 16. An accepted access gives a one-cycle `rx_valid_o` pulse with the word on `rx_word_o`. A rejected access leaves `rx_word_o` unchanged and gives no pulse.
- R7: In an accepted access longer than 16 bits, the last 16 bits received form the word. After the 16 diagnosis bits, the serial output forwards the received bits in arrival order.
- R8: The error flag is set by reset, cleared by an accepted access and set by a rejected access.
- R9: After reset, `rx_valid_o` is 0, `rx_word_o` is 0 and `so_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Serial output enable (high drives the pin, low means high impedance) |
| diag_i | input | WORD_W | Diagnosis word loaded at select fall |
| rx_word_o | output | WORD_W | Last accepted received word |
| rx_valid_o | output | 1 | One-cycle strobe for an accepted word |

## Verification
The bench builds the block with its defaults: a 16-bit word, 8-bit granularity and two synchronizer stages. The serial clock runs at one sixteenth of the system clock. With these values, accesses of 8, 16, 17 and 24 bits cover each accept and reject case. The 24-bit access also shows the last-16 latching and the forwarding of the first received byte toward the chain.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;
  typedef struct packed {
    logic cs;
    logic sclk;
    logic si;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{cs: 1'b1, sclk: 1'b0, si: 1'b0};
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_frame_qual.sv
module spi_frame_qual #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned GRAN   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_i,
  output logic ok_o
);
  localparam int unsigned MOD_W = (GRAN > 1) ? $clog2(GRAN) : 1;
  localparam int unsigned TOT_W = $clog2(WORD_W + 1);

  logic [MOD_W-1:0] mod_q;
  logic [TOT_W-1:0] tot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q <= '0;
      tot_q <= '0;
    end else if (start_i) begin
      mod_q <= '0;
      tot_q <= '0;
    end else if (bit_i) begin
      mod_q <= (mod_q == MOD_W'(GRAN - 1)) ? '0 : mod_q + 1'b1;
      // saturate: only "reached WORD_W" matters
      if (tot_q != TOT_W'(WORD_W)) tot_q <= tot_q + 1'b1;
    end
  end

  assign ok_o = (mod_q == '0) && (tot_q == TOT_W'(WORD_W));
endmodule

// File: rtl/spi_diag_shifter.sv
module spi_diag_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              si_i,
  output logic [WORD_W-1:0] shreg_o,
  output logic              so_bit_o
);
  logic [WORD_W-1:0] shreg_q;
  logic              so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      so_q    <= 1'b0;
    end else begin
      if (load_i)      shreg_q <= load_val_i;
      else if (fall_i) shreg_q <= {shreg_q[WORD_W-2:0], si_i};
      if (rise_i)      so_q    <= shreg_q[WORD_W-1];
    end
  end

  assign shreg_o  = shreg_q;
  assign so_bit_o = so_q;
endmodule

// File: rtl/spi_diag_slave.sv
module spi_diag_slave
  import spi_diag_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned GRAN        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic [WORD_W-1:0] diag_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);
  localparam int unsigned PIN_W = $bits(spi_pins_t);

  spi_pins_t pins_raw, pins_s;
  logic cs_s, sclk_s, si_s;
  logic cs_q, sclk_q;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic pre_q, err_q, qual_ok, so_bit;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] rx_word_q;
  logic              rx_valid_q;

  assign pins_raw = '{cs: cs_ni, sclk: sclk_i, si: si_i};

  spi_in_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign cs_s   = pins_s.cs;
  assign sclk_s = pins_s.sclk;
  assign si_s   = pins_s.si;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  assign cs_fall   = cs_q & ~cs_s;
  assign cs_rise   = ~cs_q & cs_s;
  assign sclk_rise = ~cs_s & ~cs_fall & sclk_s & ~sclk_q;
  assign sclk_fall = ~cs_s & ~cs_fall & ~sclk_s & sclk_q;

  spi_frame_qual #(
    .WORD_W(WORD_W),
    .GRAN  (GRAN)
  ) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(cs_fall),
    .bit_i  (sclk_fall),
    .ok_o   (qual_ok)
  );

  spi_diag_shifter #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cs_fall),
    .load_val_i(diag_i),
    .rise_i    (sclk_rise),
    .fall_i    (sclk_fall),
    .si_i      (si_s),
    .shreg_o   (shreg),
    .so_bit_o  (so_bit)
  );

  // pre_q: window between select fall and first serial clock rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= 1'b0;
      err_q      <= 1'b1;
      rx_word_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (cs_fall)        pre_q <= 1'b1;
      else if (sclk_rise) pre_q <= 1'b0;
      else if (cs_s)      pre_q <= 1'b0;
      if (cs_rise) begin
        if (qual_ok) begin
          rx_word_q  <= shreg;
          rx_valid_q <= 1'b1;
          err_q      <= 1'b0;
        end else begin
          err_q      <= 1'b1;
        end
      end
    end
  end

  assign so_o       = cs_s ? 1'b0 : (pre_q ? (err_q | si_s) : so_bit);
  assign so_oe_o    = ~cs_s;
  assign rx_word_o  = rx_word_q;
  assign rx_valid_o = rx_valid_q;
endmodule

// File: rtl/spi_diag_slave_chk.sv
module spi_diag_slave_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s,
  input logic              qual_ok,
  input logic              err_q,
  input logic [WORD_W-1:0] shreg,
  input logic [WORD_W-1:0] diag_i,
  input logic [WORD_W-1:0] rx_word_o,
  input logic              rx_valid_o
);
  assert_idle_no_shift_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> $stable(shreg));

  assert_diag_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_s) |=> shreg == $past(diag_i));

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_valid_qualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(qual_ok));

  assert_word_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_word_o));

  assert_err_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !err_q);
endmodule

bind spi_diag_slave spi_diag_slave_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_s      (cs_s),
  .qual_ok   (qual_ok),
  .err_q     (err_q),
  .shreg     (shreg),
  .diag_i    (diag_i),
  .rx_word_o (rx_word_o),
  .rx_valid_o(rx_valid_o)
);

// File: tb/sim_spi_diag_slave.sv
module sim_spi_diag_slave;
  localparam int W = 16;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, si = 1'b0;
  logic [W-1:0] diag = 16'h1234;
  logic so, so_oe, rx_valid;
  logic [W-1:0] rx_word;

  int checks = 0, errors = 0;
  int vcount = 0;
  logic exp_err = 1'b1;
  logic [W-1:0] exp_word = '0;

  always #2.5 clk = ~clk;

  spi_diag_slave u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .diag_i(diag), .rx_word_o(rx_word), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) if (rx_valid) vcount++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // one access of n bits, data sent MSB first from bit n-1
  task automatic frame(input logic [31:0] data, input int n, input logic pre_si);
    logic [31:0] so_cap = '0;
    logic [31:0] so_exp = '0;
    int v0 = vcount;
    logic [W-1:0] word_before = rx_word;
    bit ok;
    si = 1'b0;
    cs_ni = 1'b0;
    wait_cyc(H);
    check(so_oe === 1'b1, "R3 enable in access", so_oe, 1);
    check(so === exp_err, "R5 SO at select fall (flag|0)", so, exp_err);
    if (pre_si) begin
      si = 1'b1;
      wait_cyc(H);
      check(so === 1'b1, "R5 SO at select fall (flag|1)", so, 1);
    end
    for (int i = 0; i < n; i++) begin
      si = data[n-1-i];
      sclk = 1'b1;
      wait_cyc(H);
      so_cap = {so_cap[30:0], so};
      sclk = 1'b0;
      wait_cyc(H);
    end
    for (int i = 0; i < n; i++)
      so_exp = {so_exp[30:0], (i < W) ? diag[W-1-i] : data[n-1-(i-W)]};
    check(so_cap === so_exp, (n > W) ? "R7 SO forwards received bits" : "R2 R4 SO diag MSB first",
          so_cap, so_exp);
    cs_ni = 1'b1;
    wait_cyc(H);
    check(so_oe === 1'b0, "R3 enable idle", so_oe, 0);
    ok = (n % 8 == 0) && (n >= W);
    if (ok) begin
      exp_word = data[W-1:0];
      exp_err  = 1'b0;
      check(vcount == v0 + 1, "R6 one strobe on accept", vcount - v0, 1);
      check(rx_word === exp_word, "R6 R7 accepted word", rx_word, exp_word);
    end else begin
      exp_err = 1'b1;
      check(vcount == v0, "R6 no strobe on reject", vcount - v0, 0);
      check(rx_word === word_before, "R6 word held on reject", rx_word, word_before);
    end
  endtask

  task automatic t_reset;
    check(rx_valid === 1'b0, "R9 valid after reset", rx_valid, 0);
    check(rx_word === '0, "R9 word after reset", rx_word, 0);
    check(so_oe === 1'b0, "R9 enable after reset", so_oe, 0);
  endtask

  task automatic t_basic16;
    frame(32'h0000_A5C3, 16, 1'b0);   // R8: flag from reset shows as 1
  endtask

  task automatic t_reject8;
    diag = 16'hC0DE;
    frame(32'h0000_005A, 8, 1'b1);    // R8: flag clear, R5 with SI high
  endtask

  task automatic t_chain24;
    diag = 16'h8E71;
    frame(32'h00DE_ADBE, 24, 1'b0);   // R8: flag set by reject
  endtask

  task automatic t_reject17;
    frame(32'h0001_3579, 17, 1'b0);
  endtask

  task automatic t_idle_activity;
    int v0 = vcount;
    for (int i = 0; i < 20; i++) begin
      si = i[0];
      sclk = ~sclk;
      wait_cyc(H);
    end
    sclk = 1'b0;
    wait_cyc(H);
    check(so_oe === 1'b0, "R1 R3 enable with select high", so_oe, 0);
    check(vcount == v0, "R1 no strobe with select high", vcount - v0, 0);
    diag = 16'h0F0F;
    frame(32'h0000_6C39, 16, 1'b0);   // R1: stray clocks did not count; R8 flag set before
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(5);
    t_reset();
    rst_ni = 1'b1;
    wait_cyc(5);
    t_reset();
    t_basic16();
    t_reject8();
    t_chain24();
    t_reject17();
    t_idle_activity();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule